// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block moves a low-power DRAM into self-refresh when the system asks it to sleep, and brings the device back into normal operation when the system asks it to wake. It drives the row strobe and both byte column strobes while the device is handed over. On entry it uses CAS-before-RAS ordering: both column strobes fall first, and the row strobe follows and stays low. Once the row strobe is low, the block refuses to release it until the minimum self-refresh hold time has passed. This keeps the device out of the undefined window in which it is switching modes internally. A wake request that arrives inside that window is remembered and acted on as soon as the window closes.

On exit all strobes rise together, so the column strobes never rise after the row strobe. The strobes then stay high for the extended exit precharge. After that the block asks the refresh scheduler for a full catch-up burst of CBR refreshes, because the refresh phase of every row is unknown when self-refresh ends. It reports awake only after the scheduler has confirmed every refresh in the burst. While the block owns the strobes it holds the scheduler off. The scheduler's strobe outputs and this block's strobe outputs are merged outside the block.

Top module: `dram_selfref_seq`

## Requirements
- R1: During reset and right after it, `awake` is 1, `ras_n`, `cas_lo_n` and `cas_hi_n` are 1, and `cat_req` and `sched_hold` are 0.
- R2: A sleep request is taken only while the block is awake and `sched_idle` is 1. A sleep request that is taken sets `awake` to 0 and `sched_hold` to 1 in the cycle after it is sampled. A sleep request at any other time changes no output.
- R3: On entry both column strobes fall and the row strobe stays high for exactly `CAS_SETUP_CYC` cycles. The row strobe then falls, and the column strobes stay low.
- R4: Once `ras_n` has fallen it stays low for at least `HOLD_MIN_CYC` cycles. A wake request that arrives during the column-setup phase or the hold window is deferred. Exit then starts in the first cycle after the window ends.
- R5: On exit `ras_n`, `cas_lo_n` and `cas_hi_n` rise in the same cycle.
- R6: After exit all strobes stay high for exactly `EXIT_PRE_CYC` cycles, with `sched_hold` at 1 and `cat_req` at 0. Then `cat_req` rises and `sched_hold` falls.
- R7: `cat_req` stays at 1 until `BURST_ROWS` pulses of `ref_done` have been counted. `awake` returns to 1, and `cat_req` to 0, in the cycle after the last pulse is sampled.
- R8: A wake request while the block is awake changes no output.
- R9: `sched_hold` is 1 from the moment a sleep request is taken until the exit precharge ends, and is 0 at all other times.
- R10: A wake request that arrives after the hold window has ended starts the exit in the cycle after it is sampled.
- R11: `ref_done` pulses outside the catch-up phase are not counted. A later catch-up still needs `BURST_ROWS` fresh pulses.
- R12: A sleep request or a wake request received during the exit precharge or the catch-up phase changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| sched_idle | input | 1 | Refresh scheduler has no refresh in flight |
| ref_done | input | 1 | One-cycle pulse per completed catch-up refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| sched_hold | output | 1 | Scheduler must keep off the strobes |
| cat_req | output | 1 | Catch-up refresh burst requested |
| awake | output | 1 | 1 when the device is in normal operation |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk`.
- `sched_idle` reports the true state of the scheduler.
- `ref_done` pulses once per completed refresh.

Nothing is assumed about how long a request lasts or when it arrives. The stimulus changes inputs only on the falling clock edge. It sends requests as single-cycle pulses, and in one case holds a sleep request for several cycles. It places wake requests in the column-setup phase, inside the hold window, after the window, while awake and during exit. It also sends stray `ref_done` pulses while the device is asleep. The only such pulses it produces inside catch-up are the ones the burst expects.

// File: rtl/sr_seq_pkg.sv
// Package: shared types and helpers for the self-refresh sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sr_seq_pkg;

    typedef enum logic [2:0] {
        SR_AWAKE     = 3'd0,
        SR_CBR_SETUP = 3'd1,
        SR_HOLD      = 3'd2,
        SR_SLEEP     = 3'd3,
        SR_EXIT_PRE  = 3'd4,
        SR_CATCHUP   = 3'd5
    } sr_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sr_phase_timer.sv
// Module: sr_phase_timer
// Counts the cycles spent in the current sequencer state. It flags the last
// cycle of the column-setup phase, of the hold window and of the exit precharge.
// Assumes: restart is 1 on each state change; every limit is at least 1.
module sr_phase_timer
    import sr_seq_pkg::*;
#(
    parameter int unsigned CAS_SETUP_CYC = 2,
    parameter int unsigned HOLD_MIN_CYC  = 10000,
    parameter int unsigned EXIT_PRE_CYC  = 11
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  sr_state_e state,
    output logic      setup_done,
    output logic      hold_done,
    output logic      pre_done
);

    localparam int unsigned MAX_LIM = max3(CAS_SETUP_CYC, HOLD_MIN_CYC, EXIT_PRE_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] LAST_SETUP = CNT_W'(CAS_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_HOLD  = CNT_W'(HOLD_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_PRE   = CNT_W'(EXIT_PRE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(MAX_LIM);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter: cleared on each state change, saturates at the largest limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the last cycle of each timed phase.
    always_comb begin
        setup_done = (state == SR_CBR_SETUP) && (cnt_q == LAST_SETUP);
        hold_done  = (state == SR_HOLD)      && (cnt_q == LAST_HOLD);
        pre_done   = (state == SR_EXIT_PRE)  && (cnt_q == LAST_PRE);
    end

    // The counter never runs past the hold limit while the hold window is open.
    AST_HOLD_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_HOLD && !restart) |-> (cnt_q <= LAST_HOLD)); // R4

endmodule

// File: rtl/sr_burst_counter.sv
// Module: sr_burst_counter
// Counts the completed catch-up refreshes reported by the scheduler. It flags
// the pulse that completes the burst.
// Assumes: ref_done pulses once per refresh; pulses while inactive are dropped.
module sr_burst_counter #(
    parameter int unsigned BURST_ROWS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_done,
    output logic burst_last
);

    localparam int unsigned BW = (BURST_ROWS > 1) ? $clog2(BURST_ROWS) : 1;
    localparam logic [BW-1:0] LAST_ROW = BW'(BURST_ROWS - 1);

    logic [BW-1:0] bcnt_q;

    // Refresh tally: counts only while the catch-up phase is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
        end else if (!active) begin
            bcnt_q <= '0;
        end else if (ref_done) begin
            bcnt_q <= (bcnt_q == LAST_ROW) ? '0 : bcnt_q + 1'b1;
        end
    end

    // Final pulse of the burst.
    assign burst_last = active && ref_done && (bcnt_q == LAST_ROW);

    // A pulse outside catch-up leaves the tally at zero.
    AST_STRAY_REF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && ref_done) |=> (bcnt_q == '0)); // R11

    // The tally never passes the burst size.
    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bcnt_q <= LAST_ROW)); // R7

endmodule

// File: rtl/sr_ctrl_fsm.sv
// Module: sr_ctrl_fsm
// State machine for the self-refresh hand-over. It accepts sleep and wake
// requests, defers a wake until the hold window ends, and decodes the strobes
// and the scheduler handshake from its state.
// Assumes: all inputs are synchronous to clk; the done flags come from
// sr_phase_timer and sr_burst_counter.
module sr_ctrl_fsm
    import sr_seq_pkg::*;
#(
    parameter int unsigned HOLD_MIN_CYC = 10000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      wake_req,
    input  logic      sched_idle,
    input  logic      setup_done,
    input  logic      hold_done,
    input  logic      pre_done,
    input  logic      burst_last,
    output sr_state_e state,
    output logic      restart,
    output logic      ras_n_o,
    output logic      cas_lo_n_o,
    output logic      cas_hi_n_o,
    output logic      sched_hold_o,
    output logic      cat_req_o,
    output logic      awake_o
);

    localparam int unsigned LEN_W = $clog2(HOLD_MIN_CYC + 1) + 1;
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(HOLD_MIN_CYC);

    sr_state_e st_q, st_nxt;
    logic      wake_pend_q;
    logic      cas_low;

    // Next state: sleep is gated by scheduler idle, and exit waits for the hold window.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            SR_AWAKE:     if (sleep_req && sched_idle) st_nxt = SR_CBR_SETUP;
            SR_CBR_SETUP: if (setup_done)              st_nxt = SR_HOLD;
            SR_HOLD:      if (hold_done)
                              st_nxt = (wake_pend_q || wake_req) ? SR_EXIT_PRE : SR_SLEEP;
            SR_SLEEP:     if (wake_req)                st_nxt = SR_EXIT_PRE;
            SR_EXIT_PRE:  if (pre_done)                st_nxt = SR_CATCHUP;
            SR_CATCHUP:   if (burst_last)              st_nxt = SR_AWAKE;
            default:                                   st_nxt = SR_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SR_AWAKE;
        else        st_q <= st_nxt;
    end

    // Deferred wake: remembered during setup and hold, dropped when the exit starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pend_q <= 1'b0;
        end else if (st_nxt == SR_EXIT_PRE) begin
            wake_pend_q <= 1'b0;
        end else if (wake_req && (st_q == SR_CBR_SETUP || st_q == SR_HOLD)) begin
            wake_pend_q <= 1'b1;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        cas_low      = (st_q == SR_CBR_SETUP) || (st_q == SR_HOLD) || (st_q == SR_SLEEP);
        ras_n_o      = !((st_q == SR_HOLD) || (st_q == SR_SLEEP));
        cas_lo_n_o   = !cas_low;
        cas_hi_n_o   = !cas_low;
        sched_hold_o = cas_low || (st_q == SR_EXIT_PRE);
        cat_req_o    = (st_q == SR_CATCHUP);
        awake_o      = (st_q == SR_AWAKE);
    end

    assign state   = st_q;
    assign restart = (st_nxt != st_q);

    // Assertion support: length of the current row-strobe low period, saturating.
    logic [LEN_W-1:0] ras_low_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                   ras_low_len_q <= '0;
        else if (ras_n_o)             ras_low_len_q <= '0;
        else if (ras_low_len_q != LEN_SAT) ras_low_len_q <= ras_low_len_q + 1'b1;
    end

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> ($past(!cas_lo_n_o && !cas_hi_n_o) && !cas_lo_n_o && !cas_hi_n_o)); // R3

    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (ras_low_len_q >= LEN_SAT)); // R4

    AST_EXIT_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (cas_lo_n_o && cas_hi_n_o)); // R5

    AST_SLEEP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && !sched_idle) |=> awake_o); // R2

    AST_WAKE_WHILE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && wake_req && !sleep_req) |=> awake_o); // R8

    AST_AWAKE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake_o) |-> $past(burst_last)); // R7

endmodule

// File: rtl/dram_selfref_seq.sv
// Module: dram_selfref_seq (top)
// Puts a DRAM into self-refresh with CBR ordering. It holds the row strobe low
// through the minimum self-refresh time, then applies the long exit precharge
// and requests a full catch-up refresh burst before reporting awake.
// Assumes: an outside merge gives these strobes the bus while sched_hold or
// low strobes say so; ref_done pulses once per completed refresh.
module dram_selfref_seq
    import sr_seq_pkg::*;
#(
    parameter int unsigned CAS_SETUP_CYC = 2,
    parameter int unsigned HOLD_MIN_CYC  = 10000,
    parameter int unsigned EXIT_PRE_CYC  = 11,
    parameter int unsigned BURST_ROWS    = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic sched_idle,
    input  logic ref_done,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic sched_hold,
    output logic cat_req,
    output logic awake
);

    sr_state_e state;
    logic      restart;
    logic      setup_done, hold_done, pre_done, burst_last;

    sr_ctrl_fsm #(
        .HOLD_MIN_CYC (HOLD_MIN_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .wake_req     (wake_req),
        .sched_idle   (sched_idle),
        .setup_done   (setup_done),
        .hold_done    (hold_done),
        .pre_done     (pre_done),
        .burst_last   (burst_last),
        .state        (state),
        .restart      (restart),
        .ras_n_o      (ras_n),
        .cas_lo_n_o   (cas_lo_n),
        .cas_hi_n_o   (cas_hi_n),
        .sched_hold_o (sched_hold),
        .cat_req_o    (cat_req),
        .awake_o      (awake)
    );

    sr_phase_timer #(
        .CAS_SETUP_CYC (CAS_SETUP_CYC),
        .HOLD_MIN_CYC  (HOLD_MIN_CYC),
        .EXIT_PRE_CYC  (EXIT_PRE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .state      (state),
        .setup_done (setup_done),
        .hold_done  (hold_done),
        .pre_done   (pre_done)
    );

    sr_burst_counter #(
        .BURST_ROWS (BURST_ROWS)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state == SR_CATCHUP),
        .ref_done   (ref_done),
        .burst_last (burst_last)
    );

    // Catch-up and scheduler hold-off never overlap.
    AST_HOLD_VS_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cat_req) |-> $fell(sched_hold)); // R9

endmodule

// File: tb/tb_dram_selfref_seq.sv
// Scoreboard bench: driver tasks queue the expected output changes with the
// cycle they must appear in; a monitor pops and compares them on each change.
module tb_dram_selfref_seq;

    localparam int CLK_PERIOD = 10;
    localparam int S = 2;   // CAS_SETUP_CYC
    localparam int H = 40;  // HOLD_MIN_CYC
    localparam int P = 3;   // EXIT_PRE_CYC
    localparam int B = 8;   // BURST_ROWS

    // Output vector order: {awake, ras_n, cas_lo_n, cas_hi_n, cat_req, sched_hold}
    localparam logic [5:0] V_AWAKE = 6'b111100;
    localparam logic [5:0] V_SETUP = 6'b010001;
    localparam logic [5:0] V_SELF  = 6'b000001;
    localparam logic [5:0] V_PRE   = 6'b011101;
    localparam logic [5:0] V_CATCH = 6'b011110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, sched_idle = 1'b1, ref_done = 1'b0;
    logic ras_n, cas_lo_n, cas_hi_n, sched_hold, cat_req, awake;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [5:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    dram_selfref_seq #(
        .CAS_SETUP_CYC (S),
        .HOLD_MIN_CYC  (H),
        .EXIT_PRE_CYC  (P),
        .BURST_ROWS    (B)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .sched_idle (sched_idle),
        .ref_done   (ref_done),
        .ras_n      (ras_n),
        .cas_lo_n   (cas_lo_n),
        .cas_hi_n   (cas_hi_n),
        .sched_hold (sched_hold),
        .cat_req    (cat_req),
        .awake      (awake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wire [5:0] outv = {awake, ras_n, cas_lo_n, cas_hi_n, cat_req, sched_hold};

    // Monitor: every output change must match the head of the queue.
    logic [5:0] prev_v;
    always @(negedge clk) begin
        if (mon_en) begin
            if (outv !== prev_v) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 R8 R11 R12 unexpected change at cycle %0d: actual %b expected %b",
                             cyc, outv, prev_v);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.v !== outv || e.at != cyc) begin
                        n_fail++;
                        $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                                 e.tag, outv, cyc, e.v, e.at);
                    end
                end
            end
            prev_v = outv;
        end
    end

    task automatic push(input int at, input logic [5:0] v, input string tag);
        exp_t e;
        e.at = at; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic at_neg(input int n);
        do @(negedge clk); while (cyc < n);
    endtask

    task automatic check_now(input logic [5:0] v, input string tag);
        n_tests++;
        if (outv !== v || exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: actual %b (pending %0d) expected %b (pending 0)",
                     tag, outv, exp_q.size(), v);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // Scheduler model for catch-up: B pulses spaced two cycles apart, starting after c0.
    task automatic catchup(input int c0, input string tag);
        at_neg(c0);
        for (int k = 0; k < B; k++) begin
            @(negedge clk);
            if (k == B - 1) push(cyc + 1, V_AWAKE, tag);
            pulse(ref_done);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int d, w;
        repeat (3) @(negedge clk);
        check_now(V_AWAKE, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now(V_AWAKE, "R1 after reset");
        prev_v = outv;
        mon_en = 1'b1;

        // R2: sleep refused while scheduler busy; R8: wake while awake ignored.
        sched_idle = 1'b0;
        pulse(sleep_req);
        repeat (4) @(negedge clk);
        check_now(V_AWAKE, "R2 sleep refused while busy");
        pulse(wake_req);
        repeat (4) @(negedge clk);
        check_now(V_AWAKE, "R8 wake while awake");
        sched_idle = 1'b1;

        // Scenario A: sleep, wake inside the hold window is deferred (R3 R4 R5 R6 R7 R9).
        @(negedge clk);
        d = cyc;
        push(d + 1,             V_SETUP, "R2 R9 sleep taken");
        push(d + 1 + S,         V_SELF,  "R3 RAS after CAS setup");
        push(d + 1 + S + H,     V_PRE,   "R4 R5 deferred exit");
        push(d + 1 + S + H + P, V_CATCH, "R6 R9 precharge then catch-up");
        pulse(sleep_req);
        at_neg(d + 1 + S + 5);
        pulse(wake_req);
        at_neg(d + 1 + S + H + 1);
        pulse(sleep_req);            // R12: ignored in precharge
        catchup(d + 1 + S + H + P, "R7 awake after burst");
        check_now(V_AWAKE, "R7 burst complete");

        // Scenario B: no early wake, stray refreshes while asleep (R10 R11 R12).
        @(negedge clk);
        d = cyc;
        push(d + 1,     V_SETUP, "R2 sleep taken again");
        push(d + 1 + S, V_SELF,  "R3 RAS fall again");
        pulse(sleep_req);
        at_neg(d + 1 + S + H + 4);
        check_now(V_SELF, "R4 stays low without wake");
        pulse(ref_done);
        pulse(ref_done);
        pulse(ref_done);
        pulse(sleep_req);
        @(negedge clk);
        w = cyc;
        push(w + 1,     V_PRE,   "R10 wake after window");
        push(w + 1 + P, V_CATCH, "R6 precharge length");
        pulse(wake_req);
        at_neg(w + 1 + P + 1);
        pulse(wake_req);             // R12: ignored during catch-up
        catchup(w + 1 + P + 2, "R11 full burst still needed");
        check_now(V_AWAKE, "R11 burst complete");

        // Scenario C: long sleep request, wake during CAS setup is deferred (R4).
        @(negedge clk);
        d = cyc;
        push(d + 1,             V_SETUP, "R2 held sleep taken");
        push(d + 1 + S,         V_SELF,  "R3 RAS fall");
        push(d + 1 + S + H,     V_PRE,   "R4 wake from setup deferred");
        push(d + 1 + S + H + P, V_CATCH, "R6 precharge");
        sleep_req = 1'b1;
        @(negedge clk);
        pulse(wake_req);
        sleep_req = 1'b0;
        catchup(d + 1 + S + H + P, "R7 awake again");
        check_now(V_AWAKE, "R7 final state");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule